// File: doc/BRIEF.md
# Clock Output Enable Controller

This block decides, for each output of a seven-output clock bank, whether that output runs. Each decision draws on four conditions. The first is a programmable assignment of three active-low enable pins to outputs. The second is a per-output software enable that can only turn an output off. The third is an optional squelch that turns an output off while the PLL feeding it reports loss of lock. The fourth is a squelch for a crystal loss-of-signal alarm. That squelch is active after reset and can be bypassed. Configuration takes its reset values at power-up, which stand in for stored defaults.

The pins, the lock flags and the alarm are asynchronous to the control clock, so each passes through a two-flop synchroniser. A registered decision stage then produces the enables and a per-output record of why each output is off. Each output clock passes through a latch-based gate whose latch is transparent only while that clock is low, so switching an enable never cuts a pulse short.

Top module: `clk_oe_ctrl`

## Requirements
- R1: After reset, pin 0 (mask register at address 0, reset value all ones) governs every output. Pin 0 low enables all outputs. Pin 0 high disables them, and each disabled output then has its pin cause bit set.
- R2: After reset, pins 1 and 2 (mask registers at addresses 1 and 2, reset value zero) have no effect on any output, whatever their level.
- R3: The software enable register (address 3, bit o for output o, reset value all ones) can only disable. A zero bit turns output o off and sets its register cause bit. A one bit leaves the output to the other conditions.
- R4: Writing mask register p (address p, bit o) assigns pin p to output o. A high level on pin p disables every output in its mask.
- R5: An output that no pin mask selects counts as pin-enabled. An output selected by several masks is pin-enabled only while every one of those pins is low.
- R6: The loss-of-lock squelch is off after reset (control register at address 4, bit 0 = 0). While it is off, loss-of-lock flags do not affect any output.
- R7: With control bit 0 set, an output whose source PLL reports loss of lock is disabled and has its lock cause bit set. The source PLL of output o is the 2-bit field at bits 2o+1:2o of address 5, reset value zero.
- R8: While the crystal alarm is high, every output is disabled and has its crystal cause bit set. The exception is when control bit 1 (address 4) is set, in which case the alarm has no effect.
- R9: A change on a pin, lock flag or alarm input, applied between clock edges, reaches the enable outputs on the third following rising edge. A register write that is captured on one rising edge takes effect on the next rising edge.
- R10: While reset is asserted, every enable is low and every gated clock stays low. Afterwards each gated clock copies its source clock while its enable is high and stays low otherwise. The gate's latch samples the enable only while the source clock is low.
- R11: Reads return the configuration registers, the effective enables at address 6 and the cause vector at address 7. The cause vector holds the pin, register, lock and crystal fields, each N_OUT bits wide, starting from the least significant end. Writes to addresses 6 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| oe_pin_ni | input | N_PIN | Active-low enable pins, asynchronous |
| pll_lol_i | input | N_PLL | Per-PLL loss-of-lock flags, asynchronous |
| xtal_los_i | input | 1 | Crystal loss-of-signal alarm, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational on address) |
| clk_src_i | input | N_OUT | Ungated output clocks |
| clk_o | output | N_OUT | Gated output clocks |
| out_en_o | output | N_OUT | Effective enable per output |
| cause_o | output | 4*N_OUT | Disable causes: pin, register, lock, crystal fields |

## Verification
Assertions in the decision stage check on every cycle that the outputs obey their conditions. Any output whose pin was high, whose software enable was zero or whose squelched PLL was out of lock must be off on the next edge, and an unbypassed crystal alarm must clear every enable. The bench scenarios cover the rest. These are the reset mapping, the fact that unmapped pins do nothing, the overlap and no-mapping rules, the exact synchroniser and write latency, the readback of status, the ignored writes to status addresses, and whether each gated clock actually pulses during the high phase.

// File: rtl/clk_oe_pkg.sv
package clk_oe_pkg;
   localparam int OE_N_OUT   = 7;
   localparam int OE_N_PIN   = 3;
   localparam int OE_N_PLL   = 3;
   localparam int OE_DATA_W  = 32;
   localparam int OE_ADDR_W  = 3;
   localparam int OE_SYNC    = 2;
   localparam int OE_N_CAUSE = 4;

   typedef enum int {
      CAUSE_PIN  = 0,
      CAUSE_REG  = 1,
      CAUSE_LOL  = 2,
      CAUSE_XTAL = 3
   } cause_e;

   function automatic int sel_width(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/clk_oe_sync.sv
module clk_oe_sync #(
   parameter int W = 1,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("clk_oe_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/clk_oe_regs.sv
module clk_oe_regs #(
   parameter int N_OUT  = 7,
   parameter int N_PIN  = 3,
   parameter int SEL_W  = 2,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 3
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   wr_i,
   input  logic [ADDR_W-1:0]      addr_i,
   input  logic [DATA_W-1:0]      wdata_i,
   input  logic [N_OUT-1:0]       stat_en_i,
   input  logic [4*N_OUT-1:0]     stat_cause_i,
   output logic [N_PIN*N_OUT-1:0] pin_map_o,
   output logic [N_OUT-1:0]       sw_en_o,
   output logic                   lol_sq_o,
   output logic                   xtal_keep_o,
   output logic [N_OUT*SEL_W-1:0] src_sel_o,
   output logic [DATA_W-1:0]      rdata_o
);
   localparam int A_SW    = N_PIN;
   localparam int A_CTRL  = N_PIN + 1;
   localparam int A_SRC   = N_PIN + 2;
   localparam int A_STAT  = N_PIN + 3;
   localparam int A_CAUSE = N_PIN + 4;
   localparam int SRC_W   = N_OUT * SEL_W;

   if ((1 << ADDR_W) < N_PIN + 5) begin : g_bad_addr
      $error("clk_oe_regs: address space too small");
   end
   if (SRC_W > DATA_W || 4 * N_OUT > DATA_W) begin : g_bad_data
      $error("clk_oe_regs: data width too small");
   end

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int idx);
      return a == ADDR_W'(idx);
   endfunction

   for (genvar p = 0; p < N_PIN; p++) begin : g_map
      localparam logic [N_OUT-1:0] MAP_RST = (p == 0) ? {N_OUT{1'b1}} : '0;
      logic [N_OUT-1:0] mask_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                    mask_q <= MAP_RST;
         else if (wr_i && hit(addr_i, p)) mask_q <= wdata_i[N_OUT-1:0];
      end
      assign pin_map_o[p*N_OUT +: N_OUT] = mask_q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sw_en_o     <= '1;
         lol_sq_o    <= 1'b0;
         xtal_keep_o <= 1'b0;
         src_sel_o   <= '0;
      end else if (wr_i) begin
         if (hit(addr_i, A_SW)) sw_en_o <= wdata_i[N_OUT-1:0];
         if (hit(addr_i, A_CTRL)) begin
            lol_sq_o    <= wdata_i[0];
            xtal_keep_o <= wdata_i[1];
         end
         if (hit(addr_i, A_SRC)) src_sel_o <= wdata_i[SRC_W-1:0];
      end
   end

   always_comb begin
      rdata_o = '0;
      for (int p = 0; p < N_PIN; p++) begin
         if (hit(addr_i, p)) rdata_o[N_OUT-1:0] = pin_map_o[p*N_OUT +: N_OUT];
      end
      if (hit(addr_i, A_SW))    rdata_o[N_OUT-1:0]   = sw_en_o;
      if (hit(addr_i, A_CTRL))  rdata_o[1:0]         = {xtal_keep_o, lol_sq_o};
      if (hit(addr_i, A_SRC))   rdata_o[SRC_W-1:0]   = src_sel_o;
      if (hit(addr_i, A_STAT))  rdata_o[N_OUT-1:0]   = stat_en_i;
      if (hit(addr_i, A_CAUSE)) rdata_o[4*N_OUT-1:0] = stat_cause_i;
   end
endmodule

// File: rtl/clk_oe_decide.sv
module clk_oe_decide #(
   parameter int N_OUT = 7,
   parameter int N_PIN = 3,
   parameter int N_PLL = 3,
   parameter int SEL_W = 2
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic [N_PIN-1:0]       pin_s_i,
   input  logic [N_PLL-1:0]       lol_s_i,
   input  logic                   los_s_i,
   input  logic [N_PIN*N_OUT-1:0] pin_map_i,
   input  logic [N_OUT-1:0]       sw_en_i,
   input  logic                   lol_sq_i,
   input  logic                   xtal_keep_i,
   input  logic [N_OUT*SEL_W-1:0] src_sel_i,
   output logic [N_OUT-1:0]       en_o,
   output logic [4*N_OUT-1:0]     cause_o
);
   import clk_oe_pkg::*;
   localparam int SEL_N = 1 << SEL_W;

   if (SEL_N < N_PLL) begin : g_bad_sel
      $error("clk_oe_decide: SEL_W cannot address every PLL");
   end

   logic [SEL_N-1:0]   lol_pad;
   logic               xtal_blk;
   logic [N_OUT-1:0]   en_d;
   logic [4*N_OUT-1:0] cause_d;

   always_comb begin
      lol_pad = '0;
      lol_pad[N_PLL-1:0] = lol_s_i;
   end
   assign xtal_blk = los_s_i & ~xtal_keep_i;

   for (genvar o = 0; o < N_OUT; o++) begin : g_out
      logic             pin_blk;
      logic [SEL_W-1:0] sel;
      logic             lol_blk;
      logic             reg_blk;

      always_comb begin
         pin_blk = 1'b0;
         for (int p = 0; p < N_PIN; p++) pin_blk = pin_blk | (pin_map_i[p*N_OUT+o] & pin_s_i[p]);
      end
      assign sel     = src_sel_i[o*SEL_W +: SEL_W];
      assign lol_blk = lol_sq_i & lol_pad[sel];
      assign reg_blk = ~sw_en_i[o];

      assign cause_d[CAUSE_PIN*N_OUT+o]  = pin_blk;
      assign cause_d[CAUSE_REG*N_OUT+o]  = reg_blk;
      assign cause_d[CAUSE_LOL*N_OUT+o]  = lol_blk;
      assign cause_d[CAUSE_XTAL*N_OUT+o] = xtal_blk;
      assign en_d[o] = ~(pin_blk | reg_blk | lol_blk | xtal_blk);

      assert_lol_squelch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (lol_sq_i && lol_pad[src_sel_i[o*SEL_W +: SEL_W]]) |=> !en_o[o]);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_o    <= '0;
         cause_o <= '0;
      end else begin
         en_o    <= en_d;
         cause_o <= cause_d;
      end
   end

   for (genvar p = 0; p < N_PIN; p++) begin : g_pin_chk
      assert_pin_mask_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
         pin_s_i[p] |=> ((en_o & $past(pin_map_i[p*N_OUT +: N_OUT])) == '0));
   end

   assert_sw_only_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((en_o & ~$past(sw_en_i)) == '0));

   assert_xtal_squelch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (los_s_i && !xtal_keep_i) |=> (en_o == '0));
endmodule

// File: rtl/clk_oe_gate.sv
module clk_oe_gate #(
   parameter int N = 7
) (
   input  logic         rst_ni,
   input  logic [N-1:0] clk_src_i,
   input  logic [N-1:0] en_i,
   output logic [N-1:0] clk_o
);
   for (genvar o = 0; o < N; o++) begin : g_gate
      logic en_lat;
      always_latch begin
         if (!rst_ni)           en_lat = 1'b0;
         else if (!clk_src_i[o]) en_lat = en_i[o];
      end
      assign clk_o[o] = clk_src_i[o] & en_lat;
   end
endmodule

// File: rtl/clk_oe_ctrl.sv
module clk_oe_ctrl #(
   parameter int N_OUT  = clk_oe_pkg::OE_N_OUT,
   parameter int N_PIN  = clk_oe_pkg::OE_N_PIN,
   parameter int N_PLL  = clk_oe_pkg::OE_N_PLL,
   parameter int DATA_W = clk_oe_pkg::OE_DATA_W,
   parameter int ADDR_W = clk_oe_pkg::OE_ADDR_W,
   parameter int SYNC   = clk_oe_pkg::OE_SYNC
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [N_PIN-1:0]   oe_pin_ni,
   input  logic [N_PLL-1:0]   pll_lol_i,
   input  logic               xtal_los_i,
   input  logic               reg_wr_i,
   input  logic [ADDR_W-1:0]  reg_addr_i,
   input  logic [DATA_W-1:0]  reg_wdata_i,
   output logic [DATA_W-1:0]  reg_rdata_o,
   input  logic [N_OUT-1:0]   clk_src_i,
   output logic [N_OUT-1:0]   clk_o,
   output logic [N_OUT-1:0]   out_en_o,
   output logic [4*N_OUT-1:0] cause_o
);
   import clk_oe_pkg::*;
   localparam int SEL_W  = sel_width(N_PLL);
   localparam int SYNC_W = N_PIN + N_PLL + 1;
   localparam logic [SYNC_W-1:0] SYNC_RST = {{N_PIN{1'b1}}, {(N_PLL+1){1'b0}}};

   if (N_OUT < 1 || N_PIN < 1 || N_PLL < 1) begin : g_bad_counts
      $error("clk_oe_ctrl: counts must be positive");
   end
   if (N_OUT > DATA_W) begin : g_bad_width
      $error("clk_oe_ctrl: N_OUT exceeds DATA_W");
   end

   logic [SYNC_W-1:0]      sync_q;
   logic [N_PIN-1:0]       pin_s;
   logic [N_PLL-1:0]       lol_s;
   logic                   los_s;
   logic [N_PIN*N_OUT-1:0] pin_map;
   logic [N_OUT-1:0]       sw_en;
   logic                   lol_sq;
   logic                   xtal_keep;
   logic [N_OUT*SEL_W-1:0] src_sel;

   clk_oe_sync #(.W(SYNC_W), .STAGES(SYNC), .RST_VAL(SYNC_RST)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   ({oe_pin_ni, pll_lol_i, xtal_los_i}),
      .q_o   (sync_q)
   );
   assign {pin_s, lol_s, los_s} = sync_q;

   clk_oe_regs #(.N_OUT(N_OUT), .N_PIN(N_PIN), .SEL_W(SEL_W), .DATA_W(DATA_W),
                 .ADDR_W(ADDR_W)) u_regs (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_i        (reg_wr_i),
      .addr_i      (reg_addr_i),
      .wdata_i     (reg_wdata_i),
      .stat_en_i   (out_en_o),
      .stat_cause_i(cause_o),
      .pin_map_o   (pin_map),
      .sw_en_o     (sw_en),
      .lol_sq_o    (lol_sq),
      .xtal_keep_o (xtal_keep),
      .src_sel_o   (src_sel),
      .rdata_o     (reg_rdata_o)
   );

   clk_oe_decide #(.N_OUT(N_OUT), .N_PIN(N_PIN), .N_PLL(N_PLL), .SEL_W(SEL_W)) u_decide (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pin_s_i    (pin_s),
      .lol_s_i    (lol_s),
      .los_s_i    (los_s),
      .pin_map_i  (pin_map),
      .sw_en_i    (sw_en),
      .lol_sq_i   (lol_sq),
      .xtal_keep_i(xtal_keep),
      .src_sel_i  (src_sel),
      .en_o       (out_en_o),
      .cause_o    (cause_o)
   );

   clk_oe_gate #(.N(N_OUT)) u_gate (
      .rst_ni   (rst_ni),
      .clk_src_i(clk_src_i),
      .en_i     (out_en_o),
      .clk_o    (clk_o)
   );
endmodule

// File: tb/clk_oe_ctrl_test.sv
`timescale 1ns/1ps
module clk_oe_ctrl_test;
   localparam int NO = 7, NP = 3, NL = 3, DW = 32, AW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] pin_n = 3'b111;
   logic [NL-1:0] lol = '0;
   logic          los = 1'b0;
   logic          wr = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic [NO-1:0] clk_g, en_o;
   logic [4*NO-1:0] cause;

   always #4 clk = ~clk;

   clk_oe_ctrl uut (
      .clk_i(clk), .rst_ni(rst_n), .oe_pin_ni(pin_n), .pll_lol_i(lol), .xtal_los_i(los),
      .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
      .clk_src_i({NO{clk}}), .clk_o(clk_g), .out_en_o(en_o), .cause_o(cause)
   );

   typedef struct {
      string          req;
      logic [NO-1:0]  en;
      logic [4*NO-1:0] cs;
   } item_t;

   item_t q[$];
   int checks = 0, errors = 0, pushed = 0, done = 0;
   bit finished = 0;

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [4*NO-1:0] cz(input logic [NO-1:0] p, input logic [NO-1:0] r,
                                         input logic [NO-1:0] l, input logic [NO-1:0] x);
      return {x, l, r, p};
   endfunction

   task automatic expect_state(input string req, input logic [NO-1:0] en,
                               input logic [4*NO-1:0] cs);
      item_t it;
      it.req = req; it.en = en; it.cs = cs;
      q.push_back(it);
      pushed++;
      wait (done == pushed);
   endtask

   task automatic wr_reg(input int a, input logic [DW-1:0] d);
      @(negedge clk); wr = 1'b1; addr = AW'(a); wdata = d;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic set_pins(input logic [NP-1:0] v);
      @(negedge clk); pin_n = v;
   endtask

   // monitor: pops expectations once inputs have settled
   initial begin
      forever begin
         item_t it;
         wait (q.size() != 0);
         repeat (6) @(posedge clk);
         @(negedge clk);
         it = q.pop_front();
         chk(it.req, "enable", 32'(en_o), 32'(it.en));
         chk(it.req, "cause", 32'(cause), 32'(it.cs));
         @(posedge clk); #1;
         chk("R10", "gated clock high phase", 32'(clk_g), 32'(it.en));
         done++;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R10", "enable in reset", 32'(en_o), 32'h0);
      @(posedge clk); #1;
      chk("R10", "gated clock in reset", 32'(clk_g), 32'h0);
      @(negedge clk); rst_n = 1'b1;

      // R1: default map, pins high
      expect_state("R1", 7'h00, cz(7'h7F, 0, 0, 0));
      // R2: only pin 0 low, pins 1 and 2 high
      set_pins(3'b110);
      expect_state("R2", 7'h7F, cz(0, 0, 0, 0));

      // R9: pin latency, raise pin 0
      @(negedge clk); pin_n = 3'b111;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R9", "enable two edges after pin change", 32'(en_o), 32'h7F);
      @(posedge clk); @(negedge clk);
      chk("R9", "enable three edges after pin change", 32'(en_o), 32'h00);
      expect_state("R1", 7'h00, cz(7'h7F, 0, 0, 0));

      set_pins(3'b000);
      expect_state("R1", 7'h7F, cz(0, 0, 0, 0));

      // R9: register write latency, R3 software disable
      wr_reg(3, 32'h7A);
      chk("R9", "enable on write edge", 32'(en_o), 32'h7F);
      @(posedge clk); @(negedge clk);
      chk("R9", "enable one edge after write", 32'(en_o), 32'h7A);
      expect_state("R3", 7'h7A, cz(0, 7'h05, 0, 0));

      // R11: readback and ignored status writes
      @(negedge clk); addr = 3'd3; #1;
      chk("R11", "read software enable", rdata, 32'h7A);
      addr = 3'd6; #1;
      chk("R11", "read status", rdata, 32'h7A);
      addr = 3'd7; #1;
      chk("R11", "read cause", rdata, 32'(cz(0, 7'h05, 0, 0)));
      addr = 3'd0; #1;
      chk("R11", "read default pin 0 mask", rdata, 32'h7F);
      wr_reg(6, 32'h0);
      wr_reg(7, 32'h0);
      expect_state("R11", 7'h7A, cz(0, 7'h05, 0, 0));
      wr_reg(3, 32'h7F);

      // R4: per-PLL style mapping
      wr_reg(0, 32'h03);
      wr_reg(1, 32'h1C);
      wr_reg(2, 32'h60);
      set_pins(3'b010);
      expect_state("R4", 7'h63, cz(7'h1C, 0, 0, 0));

      // R5: overlapping masks need every pin low
      wr_reg(2, 32'h61);
      set_pins(3'b100);
      expect_state("R5", 7'h1E, cz(7'h61, 0, 0, 0));
      // R5: output 0 left unmapped counts as enabled
      wr_reg(0, 32'h02);
      wr_reg(2, 32'h60);
      set_pins(3'b111);
      expect_state("R5", 7'h01, cz(7'h7E, 0, 0, 0));

      // R6: loss of lock ignored while squelch is off
      set_pins(3'b000);
      wr_reg(5, 32'h2950);
      @(negedge clk); lol = 3'b010;
      expect_state("R6", 7'h7F, cz(0, 0, 0, 0));
      // R7: squelch on, PLL 1 feeds outputs 2..4
      wr_reg(4, 32'h1);
      expect_state("R7", 7'h63, cz(0, 0, 7'h1C, 0));

      // R8: crystal alarm
      @(negedge clk); lol = '0;
      wr_reg(4, 32'h0);
      @(negedge clk); los = 1'b1;
      expect_state("R8", 7'h00, cz(0, 0, 0, 7'h7F));
      wr_reg(4, 32'h2);
      expect_state("R8", 7'h7F, cz(0, 0, 0, 0));

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog all: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule